// File: doc/BRIEF.md
# Colour Palette Host Port

This block holds a 256-entry colour lookup table in which each entry has three 6-bit components: red, green and blue. A host reaches the table through one narrow register interface. The host first loads a starting entry through one of two address registers, one for writes and one for reads. It then moves colour components through a single shared data register, one component per access. After the third component of an entry, the active pointer steps to the next entry. A whole run of neighbouring entries can therefore be loaded or dumped with one address setup.

A write entry reaches the table only when all three of its components have arrived. Red and green wait in staging registers until blue arrives, so a display never shows a half-updated colour. A separate pixel-side port takes an 8-bit pixel index and returns the 18-bit colour one cycle later. It runs independently of host traffic.

Top module: `pal_port_top`

## Requirements
- R1: After reset, `host_rdata` and `pix_rgb` are zero, both entry pointers are 0 and both component counters point at red. Three data writes with no address setup fill entry 0, and three data reads with no address setup return entry 0.
- R2: A host write with `host_sel`=0 loads the write pointer from `host_wdata`. Three later data writes (`host_sel`=2) store red, green and blue, in that order, into that entry. The entry is updated only on the blue write. A write with `host_sel`=3 has no effect.
- R3: A host write with `host_sel`=1 loads the read pointer. Each later data read (`host_rd` with `host_sel`=2) returns red, then green, then blue of that entry on `host_rdata`, starting in the cycle after the read strobe. `host_rdata` holds its value until the next data read.
- R4: After the blue component of an entry, the pointer in use advances by one and wraps from 255 to 0. This holds for both reads and writes.
- R5: A host write to either address register resets both component counters to red. Red and green that were staged but not yet committed are discarded, and the table entry keeps its old value.
- R6: On data writes, bits 7:6 of `host_wdata` are ignored. On data reads, bits 7:6 of `host_rdata` are always zero.
- R7: `pix_rgb` shows the entry selected by `pix_idx` one cycle after the index is presented, packed as {red[17:12], green[11:6], blue[5:0]}. If a blue write commits the same entry in that same cycle, the old colour is returned, and the new colour appears one cycle later.
- R8: Data reads leave the write pointer and write component counter unchanged. Data writes leave the read pointer and read component counter unchanged. If `host_wr` and `host_rd` are both high, the write is performed and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 2 | Register select: 0 write address, 1 read address, 2 data, 3 unused |
| host_wr | input | 1 | Host write strobe, one access per cycle |
| host_rd | input | 1 | Host read strobe, one access per cycle |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data, zero in bits 7:6 |
| pix_idx | input | 8 | Pixel-side palette index |
| pix_rgb | output | 18 | Registered colour for the pixel index |

## Verification
If a component counter drifts, the effect shows on the next data access. A read returns the wrong component, or a write lands in the wrong colour field, and a read-back or pixel lookup of that entry exposes it one cycle later. A pointer that fails to advance or to wrap corrupts the second entry of a streamed run, so the bench streams across the 255-to-0 boundary and reads the whole run back. Early commits and leaks between the read and write paths only show after an aborted entry or an interleaved sequence. The bench therefore reads entries back after both, rather than only after clean three-access writes.

// File: rtl/pal_pkg.sv
package pal_pkg;
    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    localparam logic [1:0] SEL_WADDR = 2'd0;
    localparam logic [1:0] SEL_RADDR = 2'd1;
    localparam logic [1:0] SEL_DATA  = 2'd2;
endpackage

// File: rtl/pal_ram.sv
module pal_ram #(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 6,
    localparam int ENTRIES = 1 << IDX_W,
    localparam int RGB_W   = 3 * COMP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [RGB_W-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [RGB_W-1:0] rword,
    input  logic [IDX_W-1:0] pix_idx,
    output logic [RGB_W-1:0] pix_rgb
);
    logic [RGB_W-1:0] mem [ENTRIES];
    logic [RGB_W-1:0] pix_d, pix_q;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rword = mem[raddr];

    always_comb begin
        pix_d = mem[pix_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pix_q <= '0;
        else        pix_q <= pix_d;
    end

    assign pix_rgb = pix_q;

    assert_commit_stores_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wdata));

    assert_pix_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && $stable(pix_idx)) |=> pix_rgb == mem[$past(pix_idx)]);
endmodule

// File: rtl/pal_seq.sv
module pal_seq
    import pal_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 6,
    parameter int DATA_W = 8,
    localparam int RGB_W = 3 * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        host_sel,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              ram_we,
    output logic [IDX_W-1:0]  ram_waddr,
    output logic [RGB_W-1:0]  ram_wdata,
    output logic [IDX_W-1:0]  ram_raddr,
    input  logic [RGB_W-1:0]  ram_rword
);
    typedef struct packed {
        logic [IDX_W-1:0]  wr_ptr;
        logic [IDX_W-1:0]  rd_ptr;
        phase_e            wr_ph;
        phase_e            rd_ph;
        logic [COMP_W-1:0] stg_r;
        logic [COMP_W-1:0] stg_g;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t s_d, s_q;
    logic [COMP_W-1:0] comp_in;
    logic [COMP_W-1:0] comp_out;

    assign comp_in = host_wdata[COMP_W-1:0];

    always_comb begin
        unique case (s_q.rd_ph)
            PH_RED:  comp_out = ram_rword[3*COMP_W-1:2*COMP_W];
            PH_GRN:  comp_out = ram_rword[2*COMP_W-1:COMP_W];
            default: comp_out = ram_rword[COMP_W-1:0];
        endcase
    end

    always_comb begin
        s_d       = s_q;
        ram_we    = 1'b0;
        ram_wdata = {s_q.stg_r, s_q.stg_g, comp_in};
        if (host_wr) begin
            case (host_sel)
                SEL_WADDR: begin
                    s_d.wr_ptr = host_wdata[IDX_W-1:0];
                    s_d.wr_ph  = PH_RED;
                    s_d.rd_ph  = PH_RED;
                end
                SEL_RADDR: begin
                    s_d.rd_ptr = host_wdata[IDX_W-1:0];
                    s_d.wr_ph  = PH_RED;
                    s_d.rd_ph  = PH_RED;
                end
                SEL_DATA: begin
                    case (s_q.wr_ph)
                        PH_RED: begin
                            s_d.stg_r = comp_in;
                            s_d.wr_ph = PH_GRN;
                        end
                        PH_GRN: begin
                            s_d.stg_g = comp_in;
                            s_d.wr_ph = PH_BLU;
                        end
                        PH_BLU: begin
                            ram_we     = 1'b1;
                            s_d.wr_ptr = s_q.wr_ptr + 1'b1;
                            s_d.wr_ph  = PH_RED;
                        end
                        default: s_d.wr_ph = PH_RED;
                    endcase
                end
                default: ;
            endcase
        end else if (host_rd && host_sel == SEL_DATA) begin
            s_d.rdata = DATA_W'(comp_out);
            case (s_q.rd_ph)
                PH_RED:  s_d.rd_ph = PH_GRN;
                PH_GRN:  s_d.rd_ph = PH_BLU;
                default: begin
                    s_d.rd_ph  = PH_RED;
                    s_d.rd_ptr = s_q.rd_ptr + 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{wr_ptr: '0, rd_ptr: '0, wr_ph: PH_RED, rd_ph: PH_RED,
                     stg_r: '0, stg_g: '0, rdata: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign host_rdata = s_q.rdata;
    assign ram_waddr  = s_q.wr_ptr;
    assign ram_raddr  = s_q.rd_ptr;

    assert_commit_advances_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> (s_q.wr_ph == PH_RED) && (s_q.wr_ptr == $past(s_q.wr_ptr) + 1'b1));

    assert_addr_resets_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && (host_sel == SEL_WADDR || host_sel == SEL_RADDR))
        |=> (s_q.wr_ph == PH_RED) && (s_q.rd_ph == PH_RED));

    assert_rdata_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[DATA_W-1:COMP_W] == '0);

    assert_rdata_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd && !host_wr && host_sel == SEL_DATA) |=> $stable(host_rdata));

    assert_read_keeps_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> $stable(s_q.wr_ptr) && $stable(s_q.wr_ph));

    assert_write_data_keeps_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == SEL_DATA) |=> $stable(s_q.rd_ptr) && $stable(s_q.rd_ph));
endmodule

// File: rtl/pal_port_top.sv
module pal_port_top #(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 6,
    parameter int DATA_W = 8,
    localparam int RGB_W = 3 * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        host_sel,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [IDX_W-1:0]  pix_idx,
    output logic [RGB_W-1:0]  pix_rgb
);
    logic             ram_we;
    logic [IDX_W-1:0] ram_waddr;
    logic [RGB_W-1:0] ram_wdata;
    logic [IDX_W-1:0] ram_raddr;
    logic [RGB_W-1:0] ram_rword;

    pal_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
        .ram_raddr(ram_raddr), .ram_rword(ram_rword)
    );

    pal_ram #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .raddr(ram_raddr), .rword(ram_rword),
        .pix_idx(pix_idx), .pix_rgb(pix_rgb)
    );
endmodule

// File: tb/pal_port_top_tb_top.sv
module pal_port_top_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = 8'd0;
    logic [7:0]  host_rdata;
    logic [7:0]  pix_idx = 8'd0;
    logic [17:0] pix_rgb;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pal_port_top dut_i (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .pix_idx(pix_idx), .pix_rgb(pix_rgb)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic [1:0] sel, input logic wr, input logic rd, input logic [7:0] d);
        @(negedge clk);
        host_sel = sel; host_wr = wr; host_rd = rd; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
    endtask

    task automatic set_wa(input logic [7:0] a); cyc(2'd0, 1'b1, 1'b0, a); endtask
    task automatic set_ra(input logic [7:0] a); cyc(2'd1, 1'b1, 1'b0, a); endtask
    task automatic put(input logic [7:0] d);    cyc(2'd2, 1'b1, 1'b0, d); endtask
    task automatic get(output logic [7:0] d);
        cyc(2'd2, 1'b0, 1'b1, 8'h00);
        d = host_rdata;
    endtask

    task automatic put_rgb(input logic [5:0] r, input logic [5:0] g, input logic [5:0] b);
        put({2'b00, r}); put({2'b00, g}); put({2'b00, b});
    endtask

    task automatic get_check(input string req, input logic [5:0] r, input logic [5:0] g, input logic [5:0] b);
        logic [7:0] v;
        get(v); check(req, v, {2'b00, r});
        get(v); check(req, v, {2'b00, g});
        get(v); check(req, v, {2'b00, b});
    endtask

    task automatic pix_check(input string req, input logic [7:0] idx, input logic [17:0] exp);
        @(negedge clk);
        pix_idx = idx;
        @(negedge clk);
        check(req, pix_rgb, exp);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 rdata", host_rdata, 8'h00);
        check("R1 pix", pix_rgb, 18'h0);
        rst_n = 1'b1;
        put_rgb(6'd11, 6'd22, 6'd33);
        get_check("R1 ptr0", 6'd11, 6'd22, 6'd33);
    endtask

    task automatic t_basic;
        set_wa(8'd5);
        put_rgb(6'd1, 6'd2, 6'd3);
        set_ra(8'd5);
        get_check("R2 R3 entry5", 6'd1, 6'd2, 6'd3);
        set_wa(8'd6);
        cyc(2'd3, 1'b1, 1'b0, 8'h2A);
        put_rgb(6'd63, 6'd0, 6'd42);
        set_ra(8'd6);
        get_check("R2 sel3", 6'd63, 6'd0, 6'd42);
        repeat (2) @(negedge clk);
        check("R3 hold", host_rdata, 8'd42);
    endtask

    task automatic t_upper;
        set_wa(8'd7);
        put(8'hFF); put(8'hC1); put(8'h40);
        set_ra(8'd7);
        get_check("R6 upper", 6'd63, 6'd1, 6'd0);
    endtask

    task automatic t_wrap;
        set_wa(8'd254);
        put_rgb(6'd10, 6'd11, 6'd12);
        put_rgb(6'd20, 6'd21, 6'd22);
        put_rgb(6'd30, 6'd31, 6'd32);
        set_ra(8'd254);
        get_check("R4 e254", 6'd10, 6'd11, 6'd12);
        get_check("R4 e255", 6'd20, 6'd21, 6'd22);
        get_check("R4 wrap e0", 6'd30, 6'd31, 6'd32);
    endtask

    task automatic t_abort;
        set_wa(8'd10);
        put_rgb(6'd5, 6'd6, 6'd7);
        set_wa(8'd10);
        put(8'd50); put(8'd51);
        set_ra(8'd10);
        get_check("R5 no commit", 6'd5, 6'd6, 6'd7);
        set_wa(8'd10);
        put(8'd40); put(8'd41);
        set_wa(8'd11);
        put_rgb(6'd1, 6'd1, 6'd1);
        set_ra(8'd10);
        get_check("R5 stage drop", 6'd5, 6'd6, 6'd7);
        set_ra(8'd10);
        begin
            logic [7:0] v;
            get(v); check("R5 read restart a", v, 8'd5);
            set_ra(8'd10);
            get(v); check("R5 read restart b", v, 8'd5);
        end
    endtask

    task automatic t_interleave;
        logic [7:0] v;
        set_wa(8'd30);
        set_ra(8'd5);
        put(8'd9);  get(v); check("R8 rd r", v, 8'd1);
        put(8'd8);  get(v); check("R8 rd g", v, 8'd2);
        get(v); check("R8 rd b", v, 8'd3);
        put(8'd7);
        set_ra(8'd30);
        get_check("R8 wr intact", 6'd9, 6'd8, 6'd7);
        @(negedge clk);
        host_sel = 2'd2; host_wr = 1'b1; host_rd = 1'b1; host_wdata = 8'd4;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        check("R8 both strobes", host_rdata, 8'd7);
    endtask

    task automatic t_pixel;
        pix_check("R7 e5", 8'd5, {6'd1, 6'd2, 6'd3});
        pix_check("R7 e255", 8'd255, {6'd20, 6'd21, 6'd22});
        pix_check("R7 e7", 8'd7, {6'd63, 6'd1, 6'd0});
        set_wa(8'd40);
        put_rgb(6'd12, 6'd13, 6'd14);
        set_wa(8'd40);
        put(8'd60); put(8'd61);
        @(negedge clk);
        host_sel = 2'd2; host_wr = 1'b1; host_wdata = 8'd62; pix_idx = 8'd40;
        @(negedge clk);
        host_wr = 1'b0;
        check("R7 same cycle old", pix_rgb, {6'd12, 6'd13, 6'd14});
        @(negedge clk);
        check("R7 new next", pix_rgb, {6'd60, 6'd61, 6'd62});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_upper();
        t_wrap();
        t_abort();
        t_interleave();
        t_pixel();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule